// File: doc/BRIEF.md
# Selectable Reference Divider Network

This block builds the phase-comparison references for a dual frequency synthesizer out of one oscillator clock. A 12-bit programmable divider makes node A. Node A feeds two fixed stages: one divides it by 4 (node B) and one divides it by 25 (node C). A separate 14-bit auxiliary divider, clocked from the same oscillator, makes node D. A routing mux, set by a 2-bit select code and an auxiliary-enable bit, assigns the nodes to the two references fr1 and fr2. One select bit per loop then passes fr1 or fr2 to the transmit and receive phase detectors.

Every reference is a one-cycle pulse at the oscillator clock rate. Its period in oscillator cycles is the division ratio. A reference power-down input stops all dividers. A free-running processor clock divides the oscillator by 3 or 4. The power-down input does not stop it.

Top module: `ref_divider_net`

## Requirements
- R1: While reset is held, fr1_o, fr2_o, tx_ref_o, rx_ref_o and mclk_o are all 0.
- R2: With fr1_sel_i = 2'b01, fr1_o pulses once every N cycles, where N is main_ratio_i in the range 16 to 4095.
- R3: A ratio below 16 on main_ratio_i or aux_ratio_i acts as 16, so the period is 16 cycles.
- R4: A ratio change made in the middle of a period does not shorten that period. The change takes effect from the next reload: the period in progress ends at the old length, and the periods after it use the new one.
- R5: With fr1_sel_i = 2'b10, fr1_o pulses once every 4*N cycles.
- R6: With aux_en_i = 0, fr2_o pulses once every 25*N cycles, and the value on aux_ratio_i has no effect.
- R7: With aux_en_i = 1, fr2_o pulses once every M cycles, where M is aux_ratio_i (16 to 16383). In this mode fr1_sel_i = 2'b11 gives fr1_o a period of 25*N cycles.
- R8: fr1_o stays 0 when fr1_sel_i = 2'b00, and also when fr1_sel_i = 2'b11 with aux_en_i = 0.
- R9: tx_ref_o follows fr1_o when tx_sel_i = 0 and follows fr2_o when tx_sel_i = 1. rx_ref_o uses rx_sel_i in the same way.
- R10: While ref_pd_i = 1, fr1_o, fr2_o, tx_ref_o and rx_ref_o stay 0.
- R11: mclk_o has a period of 3 cycles when mclk_div3_i = 1 and 4 cycles when it is 0, and it keeps running while ref_pd_i = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| main_ratio_i | input | 12 | Ratio of the main divider (node A) |
| aux_ratio_i | input | 14 | Ratio of the auxiliary divider (node D) |
| aux_en_i | input | 1 | Runs the auxiliary divider and routes node D to fr2 |
| fr1_sel_i | input | 2 | fr1 source: 01 selects A, 10 selects B, 11 selects C (only with the auxiliary divider on) |
| tx_sel_i | input | 1 | Transmit reference: 0 selects fr1, 1 selects fr2 |
| rx_sel_i | input | 1 | Receive reference: 0 selects fr1, 1 selects fr2 |
| ref_pd_i | input | 1 | Powers down both reference dividers |
| mclk_div3_i | input | 1 | Processor clock division: 1 divides by 3, 0 divides by 4 |
| fr1_o | output | 1 | Reference fr1 pulse |
| fr2_o | output | 1 | Reference fr2 pulse |
| tx_ref_o | output | 1 | Reference pulse for the transmit loop |
| rx_ref_o | output | 1 | Reference pulse for the receive loop |
| mclk_o | output | 1 | Processor clock |

## Verification
The hardest case to reach from the ports is a ratio change that lands in the middle of a count. The stimulus first waits for the monitor to see two fr1 pulses. It then writes the new ratio a few cycles after the second pulse and queues one interval at the old length followed by intervals at the new length. The monitor measures the gap between pulses, so this case shows whether a reload truncated the count. The stimulus also changes the auxiliary ratio while the auxiliary divider is off, to show that the fr2 period does not change. Each configuration starts from a power-down pulse, so the fixed stages begin in a known phase.

// File: rtl/ref_div_pkg.sv
package ref_div_pkg;
  localparam int MAIN_W    = 12;
  localparam int AUX_W     = 14;
  localparam int MIN_RATIO = 16;
  localparam int B_DIV     = 4;
  localparam int C_DIV     = 25;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_A    = 2'b01,
    SEL_B    = 2'b10,
    SEL_C    = 2'b11
  } fr1_sel_e;
endpackage

// File: rtl/ref_prog_div.sv
module ref_prog_div #(
  parameter int W   = 12,
  parameter int MIN = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] ratio_i,
  output logic         tc_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] load;
  logic         tc_q;

  assign load = (ratio_i < W'(MIN)) ? W'(MIN) : ratio_i;

  // ratio is sampled only on reload, so a running period is never cut short
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else begin
      tc_q  <= (cnt_q == W'(1));
      cnt_q <= (cnt_q <= W'(1)) ? load : cnt_q - W'(1);
    end
  end

  assign tc_o = tc_q;

  // R3
  no_back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> !tc_o);
endmodule

// File: rtl/ref_pulse_div.sv
module ref_pulse_div #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic in_i,
  output logic out_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (in_i) begin
      if (cnt_q == CW'(DIV - 1)) begin
        cnt_q <= '0;
        out_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CW'(1);
        out_q <= 1'b0;
      end
    end else begin
      out_q <= 1'b0;
    end
  end

  assign out_o = out_q;

  // R5
  div_follows_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_o |-> $past(in_i));
endmodule

// File: rtl/ref_mclk_gen.sv
module ref_mclk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div3_i,
  output logic mclk_o
);
  logic [1:0] cnt_q, cnt_n, lim;
  logic       mclk_q;

  assign lim   = div3_i ? 2'd2 : 2'd3;
  assign cnt_n = (cnt_q >= lim) ? 2'd0 : cnt_q + 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= 2'd0;
      mclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      mclk_q <= div3_i ? (cnt_n < 2'd1) : (cnt_n < 2'd2);
    end
  end

  assign mclk_o = mclk_q;

  // R11
  mclk_high_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mclk_o && $past(mclk_o)) |=> !mclk_o);
endmodule

// File: rtl/ref_divider_net.sv
module ref_divider_net
  import ref_div_pkg::*;
#(
  parameter int MW   = MAIN_W,
  parameter int AW   = AUX_W,
  parameter int MINR = MIN_RATIO,
  parameter int BDIV = B_DIV,
  parameter int CDIV = C_DIV
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [MW-1:0] main_ratio_i,
  input  logic [AW-1:0] aux_ratio_i,
  input  logic          aux_en_i,
  input  logic [1:0]    fr1_sel_i,
  input  logic          tx_sel_i,
  input  logic          rx_sel_i,
  input  logic          ref_pd_i,
  input  logic          mclk_div3_i,
  output logic          fr1_o,
  output logic          fr2_o,
  output logic          tx_ref_o,
  output logic          rx_ref_o,
  output logic          mclk_o
);
  logic     main_en, aux_run;
  logic     node_a, node_b, node_c, node_d;
  logic     fr1_d, fr2_d, fr1_q, fr2_q;
  fr1_sel_e sel;

  assign main_en = !ref_pd_i;
  assign aux_run = !ref_pd_i && aux_en_i;
  assign sel     = fr1_sel_e'(fr1_sel_i);

  ref_prog_div #(.W(MW), .MIN(MINR)) u_main_div (
    .clk_i, .rst_ni, .en_i(main_en), .ratio_i(main_ratio_i), .tc_o(node_a));

  ref_pulse_div #(.DIV(BDIV)) u_b_div (
    .clk_i, .rst_ni, .en_i(main_en), .in_i(node_a), .out_o(node_b));

  ref_pulse_div #(.DIV(CDIV)) u_c_div (
    .clk_i, .rst_ni, .en_i(main_en), .in_i(node_a), .out_o(node_c));

  ref_prog_div #(.W(AW), .MIN(MINR)) u_aux_div (
    .clk_i, .rst_ni, .en_i(aux_run), .ratio_i(aux_ratio_i), .tc_o(node_d));

  always_comb begin
    unique case (sel)
      SEL_A:   fr1_d = node_a;
      SEL_B:   fr1_d = node_b;
      SEL_C:   fr1_d = aux_en_i & node_c;
      default: fr1_d = 1'b0;
    endcase
    fr2_d = aux_en_i ? node_d : node_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fr1_q <= 1'b0;
      fr2_q <= 1'b0;
    end else begin
      fr1_q <= fr1_d;
      fr2_q <= fr2_d;
    end
  end

  assign fr1_o    = fr1_q;
  assign fr2_o    = fr2_q;
  assign tx_ref_o = tx_sel_i ? fr2_q : fr1_q;
  assign rx_ref_o = rx_sel_i ? fr2_q : fr1_q;

  ref_mclk_gen u_mclk (
    .clk_i, .rst_ni, .div3_i(mclk_div3_i), .mclk_o(mclk_o));

  // R8
  fr1_unused_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(fr1_sel_i) == 2'b00) || (($past(fr1_sel_i) == 2'b11) && !$past(aux_en_i)))
    |-> !fr1_o);

  // R10
  pd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_pd_i && $past(ref_pd_i) && $past(ref_pd_i, 2)) |-> (!fr1_o && !fr2_o));
endmodule

// File: tb/ref_divider_net_tb.sv
`timescale 1ns/1ps
module ref_divider_net_tb;
  import ref_div_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] main_ratio = 12'd100;
  logic [13:0] aux_ratio = 14'd50;
  logic        aux_en = 1'b0;
  logic [1:0]  fr1_sel = 2'b01;
  logic        tx_sel = 1'b0, rx_sel = 1'b0, ref_pd = 1'b0, mclk_div3 = 1'b0;
  logic        fr1, fr2, tx_ref, rx_ref, mclk;

  always #2.5 clk = ~clk;

  ref_divider_net u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .main_ratio_i(main_ratio), .aux_ratio_i(aux_ratio),
    .aux_en_i(aux_en), .fr1_sel_i(fr1_sel), .tx_sel_i(tx_sel), .rx_sel_i(rx_sel),
    .ref_pd_i(ref_pd), .mclk_div3_i(mclk_div3), .fr1_o(fr1), .fr2_o(fr2),
    .tx_ref_o(tx_ref), .rx_ref_o(rx_ref), .mclk_o(mclk));

  int    total = 0, bad = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    restart = 1'b0;
  int    npulse = 0;
  int    mon_sel = 0;
  logic  mon;

  assign mon = (mon_sel == 0) ? fr1 : (mon_sel == 1) ? fr2 :
               (mon_sel == 2) ? tx_ref : (mon_sel == 3) ? rx_ref : mclk;

  task automatic check(bit ok, string t, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  // monitor: measures rising-edge intervals and scores against the queue
  initial begin
    int   cyc = 0, last = -1, e;
    logic prev = 1'b0;
    string t;
    forever begin
      @(negedge clk);
      if (restart) begin
        last = -1; restart = 1'b0; prev = mon;
      end else begin
        if (mon && !prev) begin
          npulse++;
          if (last >= 0 && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check((cyc - last) == e, t, cyc - last, e);
          end
          last = cyc;
        end
        prev = mon;
      end
      cyc++;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_period(string t, int sel, int p, int n);
    mon_sel = sel;
    restart = 1'b1;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(p);
      tag_q.push_back(t);
    end
    wait (exp_q.size() == 0);
    step(1);
  endtask

  task automatic expect_quiet(string t, int sel, int win);
    int   edges = 0;
    logic pv;
    mon_sel = sel;
    @(negedge clk) pv = mon;
    repeat (win) begin
      @(negedge clk);
      if (mon && !pv) edges++;
      pv = mon;
    end
    check(edges == 0, t, edges, 0);
    step(1);
  endtask

  task automatic cfg(int m, int a, bit ae, logic [1:0] s, bit tx, bit rx);
    ref_pd = 1'b1;
    main_ratio = 12'(m); aux_ratio = 14'(a); aux_en = ae; fr1_sel = s;
    tx_sel = tx; rx_sel = rx;
    step(3);
    ref_pd = 1'b0;
    step(1);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    step(3);
    @(negedge clk);
    check(fr1 == 1'b0, "R1 fr1 in reset", int'(fr1), 0);
    check(fr2 == 1'b0, "R1 fr2 in reset", int'(fr2), 0);
    check(tx_ref == 1'b0, "R1 tx_ref in reset", int'(tx_ref), 0);
    check(rx_ref == 1'b0, "R1 rx_ref in reset", int'(rx_ref), 0);
    check(mclk == 1'b0, "R1 mclk in reset", int'(mclk), 0);
    step(1);
    rst_ni = 1'b1;
    step(2);

    cfg(100, 50, 0, SEL_A, 0, 1);
    expect_period("R2 fr1 node A N=100", 0, 100, 3);
    expect_period("R9 tx_ref follows fr1", 2, 100, 2);
    expect_period("R6 fr2 node C 25N", 1, 2500, 2);
    expect_period("R9 rx_ref follows fr2", 3, 2500, 1);

    cfg(20, 50, 0, SEL_B, 0, 0);
    expect_period("R5 fr1 node B 4N", 0, 80, 3);

    cfg(3, 50, 0, SEL_A, 0, 0);
    expect_period("R3 main clamp to 16", 0, 16, 3);
    expect_period("R6 fr2 with N=16", 1, 400, 2);
    aux_ratio = 14'd30;
    expect_period("R6 aux ratio ignored when off", 1, 400, 2);

    cfg(20, 30, 1, SEL_C, 1, 0);
    expect_period("R7 fr2 node D M=30", 1, 30, 3);
    expect_period("R7 fr1 node C with aux on", 0, 500, 2);
    expect_period("R9 tx_ref follows fr2", 2, 30, 2);
    expect_period("R9 rx_ref follows fr1", 3, 500, 1);

    cfg(20, 5, 1, SEL_A, 0, 0);
    expect_period("R3 aux clamp to 16", 1, 16, 3);

    cfg(20, 30, 0, SEL_C, 0, 0);
    expect_quiet("R8 fr1 code 11 with aux off", 0, 600);
    cfg(20, 30, 1, SEL_NONE, 0, 0);
    expect_quiet("R8 fr1 code 00", 0, 600);
    expect_period("R8 fr2 unaffected by code 00", 1, 30, 2);

    cfg(40, 30, 0, SEL_A, 0, 0);
    begin
      int s;
      mon_sel = 0;
      restart = 1'b1;
      step(1);
      s = npulse;
      wait (npulse == s + 2);
      step(5);
      exp_q.push_back(40); tag_q.push_back("R4 period in progress keeps old ratio");
      exp_q.push_back(20); tag_q.push_back("R4 new ratio after reload");
      exp_q.push_back(20); tag_q.push_back("R4 new ratio after reload");
      main_ratio = 12'd20;
      wait (exp_q.size() == 0);
      step(1);
    end

    cfg(20, 30, 1, SEL_A, 0, 1);
    ref_pd = 1'b1;
    step(2);
    expect_quiet("R10 fr1 in power-down", 0, 300);
    expect_quiet("R10 fr2 in power-down", 1, 300);
    expect_quiet("R10 tx_ref in power-down", 2, 300);
    expect_quiet("R10 rx_ref in power-down", 3, 300);
    mclk_div3 = 1'b0;
    expect_period("R11 mclk runs in power-down", 4, 4, 4);
    ref_pd = 1'b0;

    mclk_div3 = 1'b1;
    step(2);
    expect_period("R11 mclk divide by 3", 4, 3, 4);
    mclk_div3 = 1'b0;
    step(2);
    expect_period("R11 mclk divide by 4", 4, 4, 4);

    finish_run();
  end
endmodule